// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer with Shadow Context

This block sits next to a small processor core and takes over the work of entering and leaving interrupt handlers. It watches a set of interrupt request lines, each carrying a 3-bit priority level. It picks one winner, acknowledges it, and hands the core a new program counter when the entry sequence ends. Most sources go through a memory vector fetch. The block reads four consecutive bytes from a vector table, either a fixed table or one whose base software programs. It assembles the first three bytes into a 24-bit handler address and discards the fourth.

A single source can also be serviced through a shortcut. This needs the fast-mode bit of the priority control word to be set and the source to be at the top level, 7. On that path the current flag word and program counter are copied into shadow registers. The handler address then comes straight from a vector register, with no memory traffic. A return strobe brings the saved program counter and flags back in a fixed, short sequence. Stack pushes, register bank switching and DMA arbitration are handled elsewhere.

Top module: `irq_ctx_seq`

## Requirements
- R1: A fast entry keeps `busy` high for exactly 5 cycles, starting the cycle after acceptance. In the fifth cycle `done` and `pc_load` pulse and `new_pc` equals the vector register value sampled at acceptance.
- R2: On fast entry, `cur_pc` and `cur_flg` are captured into shadow registers. The matching return drives `new_pc` with the saved PC and `flg_out` with the saved flags, with `pc_load` and `flg_load` high in its last cycle.
- R3: A fast return keeps `busy` high for exactly 3 cycles and only then clears the active fast context.
- R4: Bit 3 of `prio_ctl` enables the fast path for level-7 requests. With that bit clear, a level-7 request is serviced through the memory vector fetch like any other source.
- R5: A normal entry lasts 5 busy cycles. In busy cycles 1 to 4 it reads vector address +0, +1, +2 and +3, one per cycle, with read data returned in the following cycle. `new_pc` is {byte+2, byte+1, byte+0}, and byte +3 has no effect.
- R6: The vector address is the table base plus 4 times the source number. The base is the parameter `FIX_BASE` when `tbl_sel` is 0, and `tbl_base` when it is 1, both sampled at acceptance.
- R7: Among requests competing for the normal path, the highest level wins and a tie goes to the lowest source number. With fast mode on, level-7 requests are excluded from this contest.
- R8: With fast mode on and more than one level-7 request present, the lowest-numbered one takes the fast path and the others stay pending. The sticky `cfg_err` output rises and stays high until reset.
- R9: No request is accepted while a sequence runs. `irq_ack` is one-hot for a single cycle, the first busy cycle, and names the accepted source.
- R10: A level-7 request is held while a fast context is active. A return strobe is ignored when no fast context is active or while a sequence is busy.
- R11: A return strobe with an active fast context, seen while idle, takes precedence over pending requests.
- R12: After reset all outputs are low and no fast context is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Level-sensitive request per source |
| irq_lvl | input | NSRC*3 | Packed 3-bit priority per source, source i at bits [3i+2:3i] |
| prio_ctl | input | 8 | Priority control word, bit 3 = fast-mode enable |
| tbl_sel | input | 1 | 0 selects fixed vector table, 1 the programmable one |
| tbl_base | input | ADRW | Programmable vector table base |
| vec_reg | input | ADRW | Fast-path handler address |
| cur_pc | input | ADRW | Core program counter |
| cur_flg | input | FLGW | Core flag word |
| fret | input | 1 | Return-from-fast-interrupt strobe |
| mem_rdata | input | 8 | Vector read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Vector byte read request |
| mem_addr | output | ADRW | Vector byte address |
| irq_ack | output | NSRC | One-hot acknowledge of the accepted source |
| new_pc | output | ADRW | Handler or return address, valid with `pc_load` |
| pc_load | output | 1 | Load `new_pc` into the core |
| flg_out | output | FLGW | Restored flags, valid with `flg_load` |
| flg_load | output | 1 | Load `flg_out` into the core |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last cycle of a sequence |
| cfg_err | output | 1 | Sticky: several level-7 requests while fast mode was on |

## Verification
The bench builds the block with its defaults: 8 sources, 24-bit addresses, 16-bit flags and a fixed table base near the top of the address space. Eight sources are enough for three-way level contests, ties, two simultaneous level-7 requests, and a normal entry nested inside an active fast context. A fixed base and a programmable base that differ in every byte make any mix-up of table select or byte order visible in `new_pc`.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_FAST = 2'd1,
    SQ_NORM = 2'd2,
    SQ_RET  = 2'd3
  } seq_e;

  localparam logic [2:0] ENTRY_LAST = 3'd4;
  localparam logic [2:0] RET_LAST   = 3'd2;
endpackage

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb
  import irq_ctx_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*LVL_W-1:0] lvl,
  input  logic                  fast_on,
  output logic                  fast_hit,
  output logic [IDW-1:0]        fast_id,
  output logic                  norm_hit,
  output logic [IDW-1:0]        norm_id,
  output logic                  multi_top
);
  logic [LVL_W-1:0] lvl_a [NSRC];
  logic [NSRC-1:0]  is_top;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign lvl_a[g]  = lvl[g*LVL_W +: LVL_W];
    assign is_top[g] = req[g] && fast_on && (lvl[g*LVL_W +: LVL_W] == LVL_TOP);
  end

  logic [LVL_W-1:0] best;
  logic [IDW:0]     n_top;

  always_comb begin
    fast_hit = 1'b0;
    fast_id  = '0;
    norm_hit = 1'b0;
    norm_id  = '0;
    best     = '0;
    n_top    = '0;
    // descending scan: a later (lower) index overwrites on equal level
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (is_top[i]) begin
        fast_hit = 1'b1;
        fast_id  = IDW'(i);
        n_top    = n_top + {{IDW{1'b0}}, 1'b1};
      end else if (req[i] && (!norm_hit || lvl_a[i] >= best)) begin
        norm_hit = 1'b1;
        best     = lvl_a[i];
        norm_id  = IDW'(i);
      end
    end
  end

  assign multi_top = (n_top > {{IDW{1'b0}}, 1'b1});
endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
  parameter int PCW  = 24,
  parameter int FLGW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_en,
  input  logic [PCW-1:0]  pc_in,
  input  logic [FLGW-1:0] flg_in,
  output logic [PCW-1:0]  sv_pc,
  output logic [FLGW-1:0] sv_flg
);
  logic [PCW-1:0]  pc_d;
  logic [FLGW-1:0] flg_d;

  always_comb begin
    pc_d  = sv_pc;
    flg_d = sv_flg;
    if (save_en) begin
      pc_d  = pc_in;
      flg_d = flg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_pc  <= '0;
      sv_flg <= '0;
    end else begin
      sv_pc  <= pc_d;
      sv_flg <= flg_d;
    end
  end
endmodule

// File: rtl/irq_ctx_vfetch.sv
module irq_ctx_vfetch #(
  parameter int              ADRW     = 24,
  parameter int              IDW      = 3,
  parameter logic [ADRW-1:0] FIX_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDW-1:0]  src_id,
  input  logic            tbl_sel,
  input  logic [ADRW-1:0] tbl_base,
  input  logic            active,
  input  logic [2:0]      cnt,
  input  logic [7:0]      rdata,
  output logic            rd,
  output logic [ADRW-1:0] addr,
  output logic [ADRW-1:0] target
);
  localparam int NBYTE = 3;

  logic [ADRW-1:0] va_q, va_d;
  logic [7:0]      byte_q [NBYTE];
  logic [7:0]      byte_d [NBYTE];

  always_comb begin
    va_d = va_q;
    if (start) va_d = (tbl_sel ? tbl_base : FIX_BASE) + (ADRW'(src_id) << 2);
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_comb begin
      byte_d[b] = byte_q[b];
      if (active && cnt == 3'(b + 1)) byte_d[b] = rdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[b] <= '0;
      else        byte_q[b] <= byte_d[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_q <= '0;
    else        va_q <= va_d;
  end

  assign rd     = active && (cnt < 3'd4);
  assign addr   = rd ? va_q + ADRW'(cnt) : '0;
  assign target = ADRW'({byte_q[2], byte_q[1], byte_q[0]});
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int              NSRC     = 8,
  parameter int              ADRW     = 24,
  parameter int              FLGW     = 16,
  parameter int              FAST_BIT = 3,
  parameter logic [ADRW-1:0] FIX_BASE = 24'hFFFE00,
  localparam int             IDW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_req,
  input  logic [NSRC*LVL_W-1:0] irq_lvl,
  input  logic [7:0]            prio_ctl,
  input  logic                  tbl_sel,
  input  logic [ADRW-1:0]       tbl_base,
  input  logic [ADRW-1:0]       vec_reg,
  input  logic [ADRW-1:0]       cur_pc,
  input  logic [FLGW-1:0]       cur_flg,
  input  logic                  fret,
  input  logic [7:0]            mem_rdata,
  output logic                  mem_rd,
  output logic [ADRW-1:0]       mem_addr,
  output logic [NSRC-1:0]       irq_ack,
  output logic [ADRW-1:0]       new_pc,
  output logic                  pc_load,
  output logic [FLGW-1:0]       flg_out,
  output logic                  flg_load,
  output logic                  busy,
  output logic                  done,
  output logic                  cfg_err
);
  seq_e            st_q, st_d;
  logic [2:0]      cnt_q, cnt_d;
  logic            fact_q, fact_d;
  logic [ADRW-1:0] vec_q, vec_d;
  logic [NSRC-1:0] ack_q, ack_d;
  logic            err_q, err_d;

  logic            fast_on;
  logic            fast_hit, norm_hit, multi_top;
  logic [IDW-1:0]  fast_id, norm_id;
  logic            go_fast, go_norm, go_ret, is_idle, last_cyc;
  logic [ADRW-1:0] sv_pc, fetch_pc;
  logic [FLGW-1:0] sv_flg;

  assign fast_on = prio_ctl[FAST_BIT];
  assign is_idle = (st_q == SQ_IDLE);

  irq_ctx_arb #(.NSRC(NSRC)) u_arb (
    .req      (irq_req),
    .lvl      (irq_lvl),
    .fast_on  (fast_on),
    .fast_hit (fast_hit),
    .fast_id  (fast_id),
    .norm_hit (norm_hit),
    .norm_id  (norm_id),
    .multi_top(multi_top)
  );

  // return strobe first, then the shortcut, then the table fetch
  assign go_ret  = is_idle && fret && fact_q;
  assign go_fast = is_idle && !go_ret && fast_hit && !fact_q;
  assign go_norm = is_idle && !go_ret && !go_fast && norm_hit;

  irq_ctx_shadow #(.PCW(ADRW), .FLGW(FLGW)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .save_en(go_fast),
    .pc_in  (cur_pc),
    .flg_in (cur_flg),
    .sv_pc  (sv_pc),
    .sv_flg (sv_flg)
  );

  irq_ctx_vfetch #(.ADRW(ADRW), .IDW(IDW), .FIX_BASE(FIX_BASE)) u_vf (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go_norm),
    .src_id  (norm_id),
    .tbl_sel (tbl_sel),
    .tbl_base(tbl_base),
    .active  (st_q == SQ_NORM),
    .cnt     (cnt_q),
    .rdata   (mem_rdata),
    .rd      (mem_rd),
    .addr    (mem_addr),
    .target  (fetch_pc)
  );

  always_comb begin
    unique case (st_q)
      SQ_RET:  last_cyc = (cnt_q == RET_LAST);
      SQ_IDLE: last_cyc = 1'b0;
      default: last_cyc = (cnt_q == ENTRY_LAST);
    endcase
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fact_d = fact_q;
    vec_d  = vec_q;
    ack_d  = '0;
    err_d  = err_q | multi_top;
    if (is_idle) begin
      cnt_d = '0;
      if (go_ret) begin
        st_d = SQ_RET;
      end else if (go_fast) begin
        st_d   = SQ_FAST;
        fact_d = 1'b1;
        vec_d  = vec_reg;
        ack_d  = NSRC'(1) << fast_id;
      end else if (go_norm) begin
        st_d  = SQ_NORM;
        ack_d = NSRC'(1) << norm_id;
      end
    end else if (last_cyc) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
      if (st_q == SQ_RET) fact_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      fact_q <= 1'b0;
      vec_q  <= '0;
      ack_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fact_q <= fact_d;
      vec_q  <= vec_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_FAST: new_pc = vec_q;
      SQ_NORM: new_pc = fetch_pc;
      SQ_RET:  new_pc = sv_pc;
      default: new_pc = '0;
    endcase
  end

  assign busy     = !is_idle;
  assign done     = last_cyc;
  assign pc_load  = last_cyc;
  assign flg_load = last_cyc && (st_q == SQ_RET);
  assign flg_out  = flg_load ? sv_flg : '0;
  assign irq_ack  = ack_q;
  assign cfg_err  = err_q;

  AST_ACK_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_ack)); // R9
  AST_ACK_FIRST:   assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> (irq_ack == '0)); // R9
  AST_DONE_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R9
  AST_FLG_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n) flg_load |-> pc_load); // R2
  AST_ERR_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R8
  AST_ADDR_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                     (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADRW'(1))); // R5
  AST_NO_RD_FAST:  assert property (@(posedge clk) disable iff (!rst_n) (st_q == SQ_FAST) |-> !mem_rd); // R1
endmodule

// File: tb/sim_irq_ctx_seq.sv
module sim_irq_ctx_seq;
  localparam int NSRC = 8;
  localparam logic [23:0] FIXB = 24'hFFFE00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_req = '0;
  logic [23:0] irq_lvl = '0;
  logic [7:0]  prio_ctl = '0;
  logic        tbl_sel = 1'b0;
  logic [23:0] tbl_base = '0, vec_reg = '0, cur_pc = '0;
  logic [15:0] cur_flg = '0;
  logic        fret = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rd, pc_load, flg_load, busy, done, cfg_err;
  logic [23:0] mem_addr, new_pc;
  logic [7:0]  irq_ack;
  logic [15:0] flg_out;

  irq_ctx_seq u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] memf(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // vector memory with one-cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  // behavioural reference model, updated at each rising edge
  int m_mode = 0, m_cnt = 0;
  bit m_fact = 0, m_err = 0;
  logic [23:0] m_svp = '0, m_vec = '0, m_va = '0;
  logic [15:0] m_svf = '0;
  logic [7:0]  m_ack = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_fact = 0; m_err = 0; m_ack = '0;
    end else begin
      int n7, fid, nid, best;
      bit fon;
      fon = prio_ctl[3];
      n7 = 0; fid = -1; nid = -1; best = -1;
      for (int i = 0; i < NSRC; i++) begin
        int lv;
        lv = int'(irq_lvl[i*3 +: 3]);
        if (irq_req[i] && fon && lv == 7) begin
          n7++;
          if (fid < 0) fid = i;
        end else if (irq_req[i] && lv > best) begin
          best = lv; nid = i;
        end
      end
      if (n7 > 1) m_err = 1;
      m_ack = '0;
      if (m_mode == 0) begin
        m_cnt = 0;
        if (fret && m_fact) m_mode = 3;
        else if (fid >= 0 && !m_fact) begin
          m_mode = 1; m_fact = 1; m_svp = cur_pc; m_svf = cur_flg; m_vec = vec_reg;
          m_ack = 8'(1) << fid;
        end else if (nid >= 0) begin
          m_mode = 2; m_va = (tbl_sel ? tbl_base : FIXB) + 24'(nid * 4);
          m_ack = 8'(1) << nid;
        end
      end else if (m_cnt == ((m_mode == 3) ? 2 : 4)) begin
        if (m_mode == 3) m_fact = 0;
        m_mode = 0; m_cnt = 0;
      end else m_cnt++;
    end
  end

  // monitor and per-cycle comparison, away from the active edge
  int run_len = 0, last_len = 0, busy_seen = 0, rd_seen = 0;
  logic [23:0] last_pc = '0;
  logic [15:0] last_flg = '0;
  int ack_log[$];

  always @(negedge clk) if (rst_n) begin
    bit e_done;
    logic [23:0] e_pc;
    e_done = (m_mode != 0) && (m_cnt == ((m_mode == 3) ? 2 : 4));
    chk(busy == (m_mode != 0), "R9 busy", 32'(busy), 32'(m_mode != 0));
    chk(done == e_done && pc_load == e_done, "R1/R3/R5 done", 32'({done, pc_load}), 32'({e_done, e_done}));
    chk(flg_load == (e_done && m_mode == 3), "R2 flg_load", 32'(flg_load), 32'(e_done && m_mode == 3));
    chk(irq_ack == m_ack, "R7/R9 ack", 32'(irq_ack), 32'(m_ack));
    chk(cfg_err == m_err, "R8 cfg_err", 32'(cfg_err), 32'(m_err));
    chk(mem_rd == (m_mode == 2 && m_cnt < 4), "R5 mem_rd", 32'(mem_rd), 32'(m_mode == 2 && m_cnt < 4));
    if (mem_rd) chk(mem_addr == m_va + 24'(m_cnt), "R5/R6 mem_addr", 32'(mem_addr), 32'(m_va + 24'(m_cnt)));
    if (pc_load) begin
      e_pc = (m_mode == 1) ? m_vec : (m_mode == 3) ? m_svp
           : {memf(m_va + 24'd2), memf(m_va + 24'd1), memf(m_va)};
      chk(new_pc == e_pc, "R1/R2/R5 new_pc", 32'(new_pc), 32'(e_pc));
    end
    if (flg_load) chk(flg_out == m_svf, "R2 flg_out", 32'(flg_out), 32'(m_svf));
    if (busy) begin run_len++; busy_seen++; end
    if (done) begin last_len = run_len; run_len = 0; last_pc = new_pc; if (flg_load) last_flg = flg_out; end
    if (mem_rd) rd_seen++;
    for (int i = 0; i < NSRC; i++) if (irq_ack[i]) ack_log.push_back(i);
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      irq_req = irq_req & ~irq_ack;
    end
  endtask

  task automatic raise(input int src, input int lv);
    irq_lvl[src*3 +: 3] = 3'(lv);
    irq_req[src] = 1'b1;
  endtask

  task automatic pulse_fret;
    fret = 1'b1; tick(1); fret = 1'b0;
  endtask

  function automatic logic [23:0] vtgt(input logic [23:0] va);
    return {memf(va + 24'd2), memf(va + 24'd1), memf(va)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk({busy, done, pc_load, flg_load, mem_rd, cfg_err} == '0 && irq_ack == '0, "R12 reset outputs",
        32'({busy, done, pc_load, flg_load, mem_rd, cfg_err, irq_ack}), 0);
    rst_n = 1'b1;
    tick(2);
    chk(busy == 1'b0, "R12 idle after reset", 32'(busy), 0);

    // normal entry, fixed table
    raise(2, 3); tick(9);
    chk(last_pc == vtgt(FIXB + 24'd8), "R5 fixed-table target", 32'(last_pc), 32'(vtgt(FIXB + 24'd8)));
    chk(last_len == 5, "R5 normal length", 32'(last_len), 5);

    // normal entry, programmable table
    tbl_sel = 1'b1; tbl_base = 24'h012340;
    raise(5, 1); tick(9);
    chk(last_pc == vtgt(24'h012354), "R6 programmable-table target", 32'(last_pc), 32'(vtgt(24'h012354)));
    tbl_sel = 1'b0;

    // level contest with a tie
    ack_log.delete();
    raise(1, 2); raise(4, 5); raise(6, 5); tick(24);
    chk(ack_log.size() == 3 && ack_log[0] == 4 && ack_log[1] == 6 && ack_log[2] == 1, "R7 order 4,6,1",
        32'(ack_log.size() > 0 ? ack_log[0] : -1), 4);

    // fast entry and return
    prio_ctl = 8'h08; vec_reg = 24'hABCDE0; cur_pc = 24'h111111; cur_flg = 16'h0F0F;
    raise(3, 7); tick(9);
    chk(last_pc == 24'hABCDE0, "R1 fast target", 32'(last_pc), 32'hABCDE0);
    chk(last_len == 5, "R1 fast length", 32'(last_len), 5);
    cur_pc = 24'h222222; cur_flg = 16'h1234;
    pulse_fret(); tick(5);
    chk(last_pc == 24'h111111 && last_flg == 16'h0F0F, "R2 restored context", 32'({last_pc, last_flg[7:0]}), 32'h11111100 | 32'h0F);
    chk(last_len == 3, "R3 return length", 32'(last_len), 3);

    // return strobe with no fast context
    busy_seen = 0; pulse_fret(); tick(5);
    chk(busy_seen == 0, "R10 stray return ignored", 32'(busy_seen), 0);

    // level 7 with fast mode off goes to memory
    prio_ctl = 8'h00; rd_seen = 0; raise(0, 7); tick(9);
    chk(rd_seen == 4 && last_pc == vtgt(FIXB), "R4 level 7 via table", 32'(rd_seen), 4);

    // two level-7 requests with fast mode on
    prio_ctl = 8'h08; ack_log.delete(); cur_pc = 24'h333333; cur_flg = 16'hBEEF;
    raise(2, 7); raise(5, 7); tick(12);
    chk(cfg_err == 1'b1, "R8 error raised", 32'(cfg_err), 1);
    chk(ack_log.size() == 1 && ack_log[0] == 2, "R8 lowest first, other held", 32'(ack_log.size()), 1);
    // normal entry nested inside fast context, return strobe during busy ignored
    raise(1, 4); tick(2); pulse_fret(); tick(8);
    chk(ack_log.size() == 2 && ack_log[1] == 1, "R10 held level 7 while fast active", 32'(ack_log.size()), 2);
    // return strobe beats the pending level-7 request
    pulse_fret(); tick(5);
    chk(last_pc == 24'h333333 && last_flg == 16'hBEEF, "R11 return before pending", 32'(last_pc), 32'h333333);
    tick(8);
    chk(ack_log.size() == 3 && ack_log[2] == 5, "R8 held source served after return", 32'(ack_log.size()), 3);
    pulse_fret(); tick(6);
    chk(cfg_err == 1'b1, "R8 error sticky", 32'(cfg_err), 1);
    chk(busy == 1'b0, "R9 idle at end", 32'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule